// File: doc/BRIEF.md
# Repeat-Mode Write Burst Expander

This block turns 32-bit processor accesses into requests on a 64-bit memory data bus. It holds a small mode register that software changes with a control write. Each flag in the register has its own set bit and its own clear bit, and the same write also loads a 7-bit repeat count. When repeat mode is off, a write goes out as one request of length 4 followed by one beat. The byte enables choose the 32-bit half given by address bit 2.

When repeat mode is on, a single 32-bit write becomes a burst. The word is copied into both halves of every 64-bit beat. The request length field carries the repeat count. Count bits [6:3] plus one give the number of beats, and count bits [2:0] select how many low bytes of the final beat are written, so exactly count+1 bytes are stored. A read issued while repeat mode is on is refused with an error pulse and never reaches memory.

The request and the data beats each use a valid/ready handshake. The processor sees a one-cycle acknowledge only after the final beat has been accepted.

Top module: `rbx_burst_expander`

## Requirements
- R1: With repeat off, a write issues one request with length 4 and the write flag set, then one beat with last=1. The beat carries the word in both halves, with byte enables 0x0F when address bit 2 is 0 and 0xF0 when it is 1.
- R2: With repeat on, a write issues one request whose length equals the repeat count, followed by count[6:3]+1 beats. Only the final beat has last=1.
- R3: Every beat of a repeat burst carries the 32-bit write word in bits [31:0] and again in bits [63:32].
- R4: In a repeat burst, every beat except the final one has enables 0xFF. The final beat enables bytes 0 through count[2:0], so the burst writes count+1 bytes in total.
- R5: With a repeat count of 15, a write produces exactly two beats, both with enables 0xFF, so the word is stored four times.
- R6: cpu_ack is a one-cycle pulse in the cycle after the final beat is accepted. A read with repeat off issues one request with length 4 and the write flag clear, sends no beats, and is acknowledged in the cycle after its request is accepted.
- R7: A read accepted while repeat is on raises cpu_err for one cycle, with no request, no beat and no acknowledge.
- R8: A control write updates the mode flags through these bit pairs: repeat set 8 / clear 7, bus-extension set 10 / clear 9, upper-half set 13 / clear 12. A pair with both bits at 1 leaves its flag unchanged. Bits [6:0] always load the repeat count. Results are visible on the cycle after the write.
- R9: irq_raise sets irq_pending, and a control write with bit 11 clears it. When both occur in the same cycle, the flag is set.
- R10: While a request or beat is valid and not ready, it stays valid and its payload holds steady. No beat appears before the request has been accepted.
- R11: After reset, all mode flags and the count are 0, no request or beat is valid, and cpu_ready is 1.
- R12: A burst uses the mode and count captured when the processor access was accepted. Control writes made during the burst do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ctl_we | input | 1 | Control write strobe |
| ctl_wdata | input | 14 | Control word: count [6:0], set/clear bits [13:7] |
| irq_raise | input | 1 | Sets the pending interrupt flag |
| cpu_valid | input | 1 | Processor access valid |
| cpu_write | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Access address |
| cpu_wdata | input | 32 | Write word |
| cpu_ready | output | 1 | Access accepted when high with cpu_valid |
| cpu_ack | output | 1 | Access completed (one-cycle pulse) |
| cpu_err | output | 1 | Read refused in repeat mode (one-cycle pulse) |
| mem_req_valid | output | 1 | Request valid |
| mem_req_ready | input | 1 | Request accepted |
| mem_req_write | output | 1 | Request direction |
| mem_req_addr | output | 32 | Request address |
| mem_req_len | output | 7 | Length field: 4 or repeat count |
| mem_dat_valid | output | 1 | Data beat valid |
| mem_dat_ready | input | 1 | Data beat accepted |
| mem_dat_data | output | 64 | Beat data |
| mem_dat_be | output | 8 | Beat byte enables |
| mem_dat_last | output | 1 | Final beat marker |
| mode_repeat | output | 1 | Repeat mode flag |
| mode_upper | output | 1 | Upper-half mode flag |
| mode_ebus | output | 1 | Bus-extension mode flag |
| mode_count | output | 7 | Repeat count |
| irq_pending | output | 1 | Pending interrupt flag |

## Verification
A wrong beat counter or captured count shows up on the same beat, as a misplaced last flag, a wrong mask on the final beat, or a burst that runs too long. Checking every accepted beat against count[6:3] and count[2:0] therefore catches the fault within one burst. A corrupt mode flag appears on the mode outputs on the cycle after the control write. It also shows in the length of the next request or in an unexpected error pulse. A sequencer stuck outside its idle state holds cpu_ready low, and the next access then times out.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  localparam int CTL_W      = 14;
  localparam int B_RPT_CLR  = 7;
  localparam int B_RPT_SET  = 8;
  localparam int B_EBUS_CLR = 9;
  localparam int B_EBUS_SET = 10;
  localparam int B_IRQ_CLR  = 11;
  localparam int B_UP_CLR   = 12;
  localparam int B_UP_SET   = 13;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_REQ  = 3'd1,
    S_DATA = 3'd2,
    S_DONE = 3'd3,
    S_ERR  = 3'd4
  } seq_state_t;

  // Set/clear update; both bits high keeps the current value.
  function automatic logic set_clr(logic cur, logic s, logic c);
    if (s && !c)      return 1'b1;
    else if (c && !s) return 1'b0;
    else              return cur;
  endfunction
endpackage

// File: rtl/rbx_mode_reg.sv
module rbx_mode_reg
  import rbx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             irq_raise,
  output logic             rpt,
  output logic             upper,
  output logic             ebus,
  output logic             irq_pend,
  output logic [CNT_W-1:0] cnt
);
  logic             rpt_q, upper_q, ebus_q, irq_q;
  logic             rpt_d, upper_d, ebus_d, irq_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_en;

  always_comb begin
    rpt_d   = set_clr(rpt_q,   ctl_wdata[B_RPT_SET],  ctl_wdata[B_RPT_CLR]);
    upper_d = set_clr(upper_q, ctl_wdata[B_UP_SET],   ctl_wdata[B_UP_CLR]);
    ebus_d  = set_clr(ebus_q,  ctl_wdata[B_EBUS_SET], ctl_wdata[B_EBUS_CLR]);
    cnt_d   = ctl_wdata[CNT_W-1:0];
    irq_en  = irq_raise || (ctl_we && ctl_wdata[B_IRQ_CLR]);
    irq_d   = irq_raise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpt_q   <= 1'b0;
      upper_q <= 1'b0;
      ebus_q  <= 1'b0;
      cnt_q   <= '0;
    end else if (ctl_we) begin
      rpt_q   <= rpt_d;
      upper_q <= upper_d;
      ebus_q  <= ebus_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  assign rpt      = rpt_q;
  assign upper    = upper_q;
  assign ebus     = ebus_q;
  assign irq_pend = irq_q;
  assign cnt      = cnt_q;

  assert_both_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we && ctl_wdata[B_RPT_SET] && ctl_wdata[B_RPT_CLR] |=> $stable(rpt_q));

  assert_raise_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_raise |=> irq_pend);
endmodule

// File: rtl/rbx_mask_gen.sv
module rbx_mask_gen #(
  parameter int BUS_BYTES = 8,
  localparam int SEL_W = $clog2(BUS_BYTES)
) (
  input  logic                 rpt,
  input  logic                 lane_hi,
  input  logic                 is_last,
  input  logic [SEL_W-1:0]     sel,
  output logic [BUS_BYTES-1:0] be
);
  localparam int LANE_BYTES = BUS_BYTES / 2;

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_byte
    localparam logic [SEL_W:0] IDX   = (SEL_W+1)'(i);
    localparam bit             IN_HI = (i >= LANE_BYTES);
    always_comb begin
      if (rpt) be[i] = !is_last || (IDX <= {1'b0, sel});
      else     be[i] = (lane_hi == IN_HI);
    end
  end
endmodule

// File: rtl/rbx_burst_seq.sv
module rbx_burst_seq
  import rbx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_rpt,
  input  logic [CNT_W-1:0] mode_cnt,
  input  logic             cpu_valid,
  input  logic             cpu_write,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_wdata,
  output logic             cpu_ready,
  output logic             cpu_ack,
  output logic             cpu_err,
  output logic             req_valid,
  input  logic             req_ready,
  output logic             req_write,
  output logic [AW-1:0]    req_addr,
  output logic [CNT_W-1:0] req_len,
  output logic             dat_valid,
  input  logic             dat_ready,
  output logic [2*DW-1:0]  dat_data,
  output logic             dat_last,
  output logic             rpt_active,
  output logic             lane_hi,
  output logic [$clog2(DW/4)-1:0] tail_sel
);
  localparam int LANE_BYTES = DW / 8;
  localparam int BUS_BYTES  = 2 * LANE_BYTES;
  localparam int SEL_W      = $clog2(BUS_BYTES);
  localparam int BEAT_W     = CNT_W - SEL_W;
  localparam int LANE_BIT   = $clog2(LANE_BYTES);
  localparam logic [CNT_W-1:0] NORMAL_LEN = CNT_W'(LANE_BYTES);

  seq_state_t        state_q, state_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic              beat_en;
  logic              cap;
  logic              wr_q, rpt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     data_q;
  logic              last_beat;

  assign last_beat = !rpt_q || (beat_q == cnt_q[CNT_W-1:SEL_W]);

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    beat_en = 1'b0;
    cap     = 1'b0;
    case (state_q)
      S_IDLE: if (cpu_valid) begin
        if (!cpu_write && mode_rpt) state_d = S_ERR;
        else begin
          state_d = S_REQ;
          cap     = 1'b1;
        end
      end
      S_REQ: if (req_ready) begin
        state_d = wr_q ? S_DATA : S_DONE;
        beat_d  = '0;
        beat_en = 1'b1;
      end
      S_DATA: if (dat_ready) begin
        if (last_beat) state_d = S_DONE;
        else begin
          beat_d  = beat_q + 1'b1;
          beat_en = 1'b1;
        end
      end
      S_DONE:  state_d = S_IDLE;
      S_ERR:   state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= S_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= 1'b0;
      rpt_q <= 1'b0;
      cnt_q <= '0;
    end else if (cap) begin
      wr_q  <= cpu_write;
      rpt_q <= mode_rpt;
      cnt_q <= mode_cnt;
    end
  end

  always_ff @(posedge clk) begin
    if (cap) begin
      addr_q <= cpu_addr;
      data_q <= cpu_wdata;
    end
  end

  assign cpu_ready  = (state_q == S_IDLE);
  assign cpu_ack    = (state_q == S_DONE);
  assign cpu_err    = (state_q == S_ERR);
  assign req_valid  = (state_q == S_REQ);
  assign dat_valid  = (state_q == S_DATA);
  assign req_write  = wr_q;
  assign req_addr   = addr_q;
  assign req_len    = rpt_q ? cnt_q : NORMAL_LEN;
  assign dat_data   = {data_q, data_q};
  assign dat_last   = dat_valid && last_beat;
  assign rpt_active = rpt_q;
  assign lane_hi    = addr_q[LANE_BIT];
  assign tail_sel   = cnt_q[SEL_W-1:0];

  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_len) && $stable(req_addr));

  assert_dat_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && !dat_ready |=> dat_valid && $stable(dat_data) && $stable(dat_last));

  assert_ack_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ack && req_write |-> $past(dat_valid && dat_ready && dat_last));

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_err |-> $past(cpu_valid && !cpu_write && mode_rpt));

  assert_beat_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid && rpt_q |-> beat_q <= cnt_q[CNT_W-1:SEL_W]);
endmodule

// File: rtl/rbx_burst_expander.sv
module rbx_burst_expander
  import rbx_pkg::*;
#(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int CNT_W = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ctl_we,
  input  logic [CTL_W-1:0]   ctl_wdata,
  input  logic               irq_raise,
  input  logic               cpu_valid,
  input  logic               cpu_write,
  input  logic [AW-1:0]      cpu_addr,
  input  logic [DW-1:0]      cpu_wdata,
  output logic               cpu_ready,
  output logic               cpu_ack,
  output logic               cpu_err,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [AW-1:0]      mem_req_addr,
  output logic [CNT_W-1:0]   mem_req_len,
  output logic               mem_dat_valid,
  input  logic               mem_dat_ready,
  output logic [2*DW-1:0]    mem_dat_data,
  output logic [DW/4-1:0]    mem_dat_be,
  output logic               mem_dat_last,
  output logic               mode_repeat,
  output logic               mode_upper,
  output logic               mode_ebus,
  output logic [CNT_W-1:0]   mode_count,
  output logic               irq_pending
);
  localparam int BUS_BYTES = DW / 4;
  localparam int SEL_W     = $clog2(BUS_BYTES);

  logic [1:0]       rst_pipe_q;
  logic             rst_sync_n;
  logic             rpt_active, lane_hi;
  logic [SEL_W-1:0] tail_sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  rbx_mode_reg #(.CNT_W(CNT_W)) u_mode (
    .clk(clk), .rst_n(rst_sync_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .irq_raise(irq_raise), .rpt(mode_repeat), .upper(mode_upper),
    .ebus(mode_ebus), .irq_pend(irq_pending), .cnt(mode_count)
  );

  rbx_burst_seq #(.DW(DW), .AW(AW), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .mode_rpt(mode_repeat), .mode_cnt(mode_count),
    .cpu_valid(cpu_valid), .cpu_write(cpu_write), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_ack(cpu_ack),
    .cpu_err(cpu_err), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_write(mem_req_write), .req_addr(mem_req_addr), .req_len(mem_req_len),
    .dat_valid(mem_dat_valid), .dat_ready(mem_dat_ready), .dat_data(mem_dat_data),
    .dat_last(mem_dat_last), .rpt_active(rpt_active), .lane_hi(lane_hi),
    .tail_sel(tail_sel)
  );

  rbx_mask_gen #(.BUS_BYTES(BUS_BYTES)) u_mask (
    .rpt(rpt_active), .lane_hi(lane_hi), .is_last(mem_dat_last),
    .sel(tail_sel), .be(mem_dat_be)
  );

  assert_tail_bytes_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dat_valid && mem_dat_last && rpt_active |->
      $countones(mem_dat_be) == int'(tail_sel) + 1);

  assert_normal_half_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    mem_dat_valid && !rpt_active |-> $countones(mem_dat_be) == BUS_BYTES / 2);
endmodule

// File: tb/rbx_burst_expander_bench.sv
module rbx_burst_expander_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we = 1'b0;
  logic [13:0] ctl_wdata = '0;
  logic        irq_raise = 1'b0;
  logic        cpu_valid = 1'b0, cpu_write = 1'b0;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready, cpu_ack, cpu_err;
  logic        mem_req_valid, mem_req_ready, mem_req_write;
  logic [31:0] mem_req_addr;
  logic [6:0]  mem_req_len;
  logic        mem_dat_valid, mem_dat_ready, mem_dat_last;
  logic [63:0] mem_dat_data;
  logic [7:0]  mem_dat_be;
  logic        mode_repeat, mode_upper, mode_ebus, irq_pending;
  logic [6:0]  mode_count;

  always #4 clk = ~clk;

  rbx_burst_expander u_rbx_burst_expander (.*);

  int checks = 0, errors = 0, cycles = 0, rdy_pct = 100;
  bit m_rpt, m_up, m_eb, m_irq;
  logic [6:0] m_cnt;
  int   x_kind, x_beats, x_sel, seen_req, seen_beats;
  bit   x_rpt, x_hi;
  logic [6:0] x_len;
  logic [31:0] x_addr, x_word;
  bit   p_req, p_dat;
  logic [6:0] p_len;
  logic [63:0] p_data;
  logic [7:0] p_be;
  logic p_last;

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_be(bit rpt, bit hi, bit last, int sel);
    if (!rpt) return hi ? 8'hF0 : 8'h0F;
    if (!last) return 8'hFF;
    return 8'((9'h1 << (sel + 1)) - 1);
  endfunction

  function automatic bit sc(bit cur, bit s, bit c);
    return (s && !c) ? 1'b1 : ((c && !s) ? 1'b0 : cur);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected <150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // Ready driver and port monitor
  initial begin
    mem_req_ready = 1'b0; mem_dat_ready = 1'b0; p_req = 0; p_dat = 0;
    forever begin
      @(negedge clk);
      mem_req_ready = ($urandom % 100) < rdy_pct;
      mem_dat_ready = ($urandom % 100) < rdy_pct;
      #1;
      if (rst_n) begin
        if (p_req) chk(mem_req_valid && mem_req_len == p_len, "R10", "req hold", mem_req_len, p_len);
        if (p_dat) chk(mem_dat_valid && mem_dat_data == p_data && mem_dat_be == p_be && mem_dat_last == p_last,
                       "R10", "beat hold", mem_dat_data, p_data);
        p_req = mem_req_valid && !mem_req_ready; p_len = mem_req_len;
        p_dat = mem_dat_valid && !mem_dat_ready;
        p_data = mem_dat_data; p_be = mem_dat_be; p_last = mem_dat_last;
        if (mem_req_valid && mem_req_ready) begin
          seen_req++;
          chk(x_kind != 2, "R7", "request on refused read", 1, 0);
          chk(mem_req_write == (x_kind == 0), "R6", "req direction", mem_req_write, x_kind == 0);
          chk(mem_req_len == x_len, x_rpt ? "R2" : "R1", "req len", mem_req_len, x_len);
          chk(mem_req_addr == x_addr, "R1", "req addr", mem_req_addr, x_addr);
        end
        if (mem_dat_valid && mem_dat_ready) begin
          chk(seen_req == 1, "R10", "beat before request", seen_req, 1);
          chk(mem_dat_data == {x_word, x_word}, "R3", "beat data", mem_dat_data, {x_word, x_word});
          chk(mem_dat_be == exp_be(x_rpt, x_hi, seen_beats == x_beats - 1, x_sel), "R4", "beat be",
              mem_dat_be, exp_be(x_rpt, x_hi, seen_beats == x_beats - 1, x_sel));
          chk(mem_dat_last == (seen_beats == x_beats - 1), "R2", "last flag", mem_dat_last, seen_beats == x_beats - 1);
          seen_beats++;
        end
      end
    end
  end

  task automatic ctl_write(logic [13:0] d, bit raise);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = d; irq_raise = raise;
    @(negedge clk);
    ctl_we = 1'b0; irq_raise = 1'b0;
    m_rpt = sc(m_rpt, d[8], d[7]);
    m_eb  = sc(m_eb, d[10], d[9]);
    m_up  = sc(m_up, d[13], d[12]);
    m_cnt = d[6:0];
    m_irq = raise ? 1'b1 : (d[11] ? 1'b0 : m_irq);
    #1;
    chk(mode_repeat == m_rpt && mode_ebus == m_eb && mode_upper == m_up, "R8", "mode flags",
        {mode_repeat, mode_ebus, mode_upper}, {m_rpt, m_eb, m_up});
    chk(mode_count == m_cnt, "R8", "count", mode_count, m_cnt);
    chk(irq_pending == m_irq, "R9", "irq pending", irq_pending, m_irq);
  endtask

  task automatic cpu_op(bit wr, logic [31:0] a, logic [31:0] d);
    int n = 0;
    bit done = 0;
    @(negedge clk);
    x_kind  = (!wr && m_rpt) ? 2 : (wr ? 0 : 1);
    x_rpt   = wr && m_rpt;
    x_len   = x_rpt ? m_cnt : 7'd4;
    x_beats = !wr ? 0 : (x_rpt ? int'(m_cnt[6:3]) + 1 : 1);
    x_sel   = int'(m_cnt[2:0]);
    x_hi    = a[2];
    x_addr  = a; x_word = d;
    seen_req = 0; seen_beats = 0;
    cpu_valid = 1'b1; cpu_write = wr; cpu_addr = a; cpu_wdata = d;
    #2;
    while (!cpu_ready) begin @(negedge clk); #2; end
    @(posedge clk);
    while (!done && n < 400) begin
      @(negedge clk);
      cpu_valid = 1'b0;
      #2;
      if (cpu_ack || cpu_err) done = 1;
      n++;
    end
    chk(done, "R6", "completion", done, 1);
    chk(cpu_err == (x_kind == 2), "R7", "error pulse", cpu_err, x_kind == 2);
    chk(cpu_ack == (x_kind != 2), "R6", "ack pulse", cpu_ack, x_kind != 2);
    chk(seen_req == (x_kind == 2 ? 0 : 1), "R7", "request count", seen_req, x_kind == 2 ? 0 : 1);
    chk(seen_beats == x_beats, x_rpt ? "R2" : "R1", "beat count", seen_beats, x_beats);
    @(negedge clk); #2;
    chk(!cpu_ack && !cpu_err, "R6", "pulse width", {cpu_ack, cpu_err}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    m_rpt = 0; m_up = 0; m_eb = 0; m_irq = 0; m_cnt = '0;
    x_kind = 1; seen_req = 0; seen_beats = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    // R11 reset state
    chk(cpu_ready && !mem_req_valid && !mem_dat_valid && !cpu_ack && !cpu_err, "R11", "idle outputs",
        {cpu_ready, mem_req_valid, mem_dat_valid}, 3'b100);
    chk(!mode_repeat && !mode_upper && !mode_ebus && !irq_pending && mode_count == 0, "R11", "mode reset",
        {mode_repeat, mode_upper, mode_ebus, irq_pending, mode_count}, 0);

    // R1 normal writes, both lanes; R6 normal read
    cpu_op(1, 32'h0000_1000, 32'hCAFE_0001);
    cpu_op(1, 32'h0000_1004, 32'hCAFE_0002);
    cpu_op(0, 32'h0000_2004, 32'h0);

    // R5 count 15 with repeat set
    ctl_write(14'h0100 | 14'd15, 0);
    cpu_op(1, 32'h0000_3000, 32'h1234_5678);
    // R4 boundaries: count 0, 10, 127
    ctl_write(14'd0, 0);
    cpu_op(1, 32'h0000_3008, 32'hA5A5_0F0F);
    ctl_write(14'd10, 0);
    cpu_op(1, 32'h0000_300C, 32'h0BAD_F00D);
    ctl_write(14'd127, 0);
    cpu_op(1, 32'h0000_3010, 32'hFFFF_0000);
    // R7 read refused in repeat mode
    cpu_op(0, 32'h0000_3020, 32'h0);

    // R8 pairs, both-bits keep
    ctl_write(14'h0180 | 14'd5, 0);          // repeat both -> stays 1
    ctl_write(14'h2400, 0);                  // upper and ebus set
    ctl_write(14'h3600 | 14'h0080, 0);       // upper both, ebus both, repeat clear
    ctl_write(14'h1200, 0);                  // upper clear, ebus clear
    // R9 irq
    ctl_write(14'h0800, 1);                  // raise with clear -> set
    ctl_write(14'h0800, 0);                  // clear

    // R12 control write during a back-pressured burst
    rdy_pct = 30;
    ctl_write(14'h0100 | 14'd39, 0);
    fork
      cpu_op(1, 32'h0000_4000, 32'h5A5A_C3C3);
      begin repeat (3) @(negedge clk); ctl_write(14'h0080 | 14'd2, 0); end
    join

    // Constrained random mix
    rdy_pct = 60;
    for (int i = 0; i < 60; i++) begin
      if (($urandom % 3) == 0) ctl_write(14'($urandom), ($urandom % 4) == 0);
      cpu_op(($urandom % 4) != 0, {$urandom} & 32'hFFFF_FFFC, $urandom);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule